// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block drives the clock-enable, on-die-termination, command-strobe, bank and address pins of a DDR2 SDRAM from reset until the memory can take normal traffic. It starts once the controller clock is stable. It steps through the mandatory start-up order, with every wait counted in controller clock cycles. The order is: a long stabilization hold, clock-enable rise, precharge-all, the three extended-register writes, a DLL reset, a second precharge-all, a series of auto-refreshes, the run-time mode write, and the driver-impedance default/exit pair. When the last step is complete, the block raises a sticky done flag.

Every wait is a parameter in clock cycles: the stabilization hold, the no-operation window after clock-enable rises, the mode-write gap, the precharge gap, the refresh gap, the refresh count and the minimum distance from the DLL reset to the impedance step. The operating fields written to the mode registers are also parameters. The block keeps termination off at all times.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is high, cke=0, odt=0, the strobes {cs_n,ras_n,cas_n,we_n}=0111 (NOP), ba=0, addr=0 and init_done=0.
- R2: After reset is released, cke stays 0 and the bus carries NOP for T_STAB cycles. cke then goes to 1 and never falls again.
- R3: After cke rises, the bus carries NOP for T_CKE cycles. It then issues precharge-all: strobes 0010, addr bit 10 = 1, all other address bits 0, ba=0.
- R4: The next three mode writes use strobes 0000 and go to ba=2, ba=3 and ba=1, in that order. The ba=2 and ba=3 writes carry addr=0. The ba=1 write carries EMR1_OPS with bit 0 (DLL enable when 0) and bits 9..7 cleared.
- R5: Next comes a write to ba=0 carrying MR_OPS with bit 8 (DLL reset) set. A second precharge-all follows it.
- R6: After the second precharge-all, exactly N_REF auto-refreshes (strobes 0001, ba=0, addr=0) are issued, with N_REF >= 2. Each refresh is followed by T_RFC NOP cycles.
- R7: After the refreshes, a write to ba=0 carries MR_OPS with bit 8 cleared.
- R8: The impedance-default write goes to ba=1 and carries the ba=1 value from R4 with bits 9..7 set to 111. It is issued on the first free cycle that lies at least T_OCD cycles after the DLL-reset write, counted from that write. NOPs fill any wait.
- R9: After T_MRD NOP cycles, a ba=1 write follows that carries the R4 value with bits 9..7 at 000.
- R10: Every command lasts one cycle. A mode write is followed by T_MRD NOP cycles and a precharge by T_RP NOP cycles. Only NOP appears between commands.
- R11: odt is 0 on every cycle.
- R12: init_done rises on the cycle after the T_MRD gap that follows the R9 write. From then on it stays 1, with cke=1 and NOP on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Memory clock enable |
| odt | output | 1 | On-die termination control, held low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address; bits 1..0 pick the mode register |
| addr | output | ADDR_W | Address bus carrying command operands |
| init_done | output | 1 | Sticky flag: initialization complete |

## Verification
All pins come from one output register stage, so each cycle of the sequence reaches the pins exactly one clock after the sequencer enters it. The first cycle after reset is released therefore shows the start of the stabilization hold. The bench builds the full expected pin timeline from the requirements, one entry per cycle. This includes the wait before the impedance step, computed as the later of the next free cycle and the DLL-reset cycle plus T_OCD. The bench compares the pins against that timeline at every falling edge, away from the rising edge that updates them. Two configurations are run: one where the impedance step must wait for the DLL-reset window, and one where the window has already expired.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

    // Command strobes {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [2:0] {
        PH_STAB,
        PH_CKE,
        PH_ISSUE,
        PH_GAP,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef enum logic [3:0] {
        ST_PRE1,
        ST_EMR2,
        ST_EMR3,
        ST_EMR1_DLL,
        ST_MR_DLLRST,
        ST_PRE2,
        ST_REF,
        ST_MR_RUN,
        ST_OCD_DFLT,
        ST_OCD_EXIT
    } step_e;

    typedef enum logic [1:0] {
        GAP_MRD,
        GAP_RP,
        GAP_RFC
    } gap_e;

    // Register select on the low two bank bits
    localparam logic [1:0] SEL_MR   = 2'd0;
    localparam logic [1:0] SEL_EMR1 = 2'd1;
    localparam logic [1:0] SEL_EMR2 = 2'd2;
    localparam logic [1:0] SEL_EMR3 = 2'd3;

    // Address bit positions with fixed meaning
    localparam int BIT_DLL_DIS = 0;
    localparam int BIT_OCD_LO  = 7;
    localparam int BIT_DLL_RST = 8;
    localparam int BIT_OCD_HI  = 9;
    localparam int BIT_PRE_ALL = 10;

    function automatic step_e step_after(step_e s);
        case (s)
            ST_PRE1:      return ST_EMR2;
            ST_EMR2:      return ST_EMR3;
            ST_EMR3:      return ST_EMR1_DLL;
            ST_EMR1_DLL:  return ST_MR_DLLRST;
            ST_MR_DLLRST: return ST_PRE2;
            ST_PRE2:      return ST_REF;
            ST_REF:       return ST_MR_RUN;
            ST_MR_RUN:    return ST_OCD_DFLT;
            default:      return ST_OCD_EXIT;
        endcase
    endfunction

    function automatic gap_e gap_kind(step_e s);
        case (s)
            ST_PRE1, ST_PRE2: return GAP_RP;
            ST_REF:           return GAP_RFC;
            default:          return GAP_MRD;
        endcase
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2i_down_timer.sv
module ddr2i_down_timer #(
    parameter int          W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr2i_age_timer.sv
module ddr2i_age_timer #(
    parameter int unsigned LIMIT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic reached
);
    localparam int          AW  = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [AW-1:0] TOP = AW'(LIMIT - 1);

    logic [AW-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)
            age_q <= '0;
        else if (start)
            age_q <= AW'(1);
        else if (age_q != '0 && age_q != TOP)
            age_q <= age_q + 1'b1;
    end

    // Next cycle lies LIMIT or more cycles after the start cycle
    assign reached = (age_q == TOP);
endmodule

// File: rtl/ddr2i_step_fsm.sv
module ddr2i_step_fsm
    import ddr2i_pkg::*;
#(
    parameter int unsigned T_CKE = 40,
    parameter int unsigned T_MRD = 2,
    parameter int unsigned T_RP  = 3,
    parameter int unsigned T_RFC = 20,
    parameter int unsigned N_REF = 2,
    parameter int          TW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          t_zero,
    input  logic          age_ok,
    output logic          t_load,
    output logic [TW-1:0] t_val,
    output logic          age_start,
    output phase_e        phase,
    output step_e         step
);
    localparam int RW = (N_REF > 2) ? $clog2(N_REF) : 1;
    localparam logic [RW-1:0] REF_LAST = RW'(N_REF - 1);

    phase_e        phase_q, phase_n;
    step_e         step_q,  step_n;
    logic [RW-1:0] ref_q,   ref_n;

    function automatic logic [TW-1:0] gap_len(gap_e g);
        case (g)
            GAP_RP:  return TW'(T_RP - 1);
            GAP_RFC: return TW'(T_RFC - 1);
            default: return TW'(T_MRD - 1);
        endcase
    endfunction

    always_comb begin
        phase_n   = phase_q;
        step_n    = step_q;
        ref_n     = ref_q;
        t_load    = 1'b0;
        t_val     = '0;
        age_start = 1'b0;
        case (phase_q)
            PH_STAB: begin
                if (t_zero) begin
                    phase_n = PH_CKE;
                    t_load  = 1'b1;
                    t_val   = TW'(T_CKE - 1);
                end
            end
            PH_CKE: begin
                if (t_zero) begin
                    phase_n = PH_ISSUE;
                    step_n  = ST_PRE1;
                end
            end
            PH_ISSUE: begin
                phase_n   = PH_GAP;
                t_load    = 1'b1;
                t_val     = gap_len(gap_kind(step_q));
                age_start = (step_q == ST_MR_DLLRST);
            end
            PH_GAP: begin
                if (t_zero) begin
                    if (step_q == ST_OCD_EXIT) begin
                        phase_n = PH_DONE;
                    end else if (step_q == ST_REF && ref_q != REF_LAST) begin
                        ref_n   = ref_q + 1'b1;
                        phase_n = PH_ISSUE;
                    end else begin
                        step_n  = step_after(step_q);
                        phase_n = (step_after(step_q) == ST_OCD_DFLT && !age_ok)
                                  ? PH_HOLD : PH_ISSUE;
                    end
                end
            end
            PH_HOLD: begin
                if (age_ok)
                    phase_n = PH_ISSUE;
            end
            default: phase_n = PH_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_STAB;
            step_q  <= ST_PRE1;
            ref_q   <= '0;
        end else begin
            phase_q <= phase_n;
            step_q  <= step_n;
            ref_q   <= ref_n;
        end
    end

    assign phase = phase_q;
    assign step  = step_q;
endmodule

// File: rtl/ddr2i_cmd_encode.sv
module ddr2i_cmd_encode
    import ddr2i_pkg::*;
#(
    parameter int              ADDR_W   = 14,
    parameter int              BA_W     = 3,
    parameter logic [ADDR_W-1:0] MR_OPS   = '0,
    parameter logic [ADDR_W-1:0] EMR1_OPS = '0,
    parameter logic [ADDR_W-1:0] EMR2_OPS = '0,
    parameter logic [ADDR_W-1:0] EMR3_OPS = '0
) (
    input  phase_e            phase,
    input  step_e             step,
    output logic              cke,
    output cmd_e              cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OCD_MASK = ADDR_W'(7) << BIT_OCD_LO;
    localparam logic [ADDR_W-1:0] DLL_RST  = ONE << BIT_DLL_RST;
    localparam logic [ADDR_W-1:0] PRE_ALL  = ONE << BIT_PRE_ALL;
    localparam logic [ADDR_W-1:0] EMR1_BASE =
        EMR1_OPS & ~OCD_MASK & ~(ONE << BIT_DLL_DIS);

    function automatic logic [BA_W-1:0] sel(logic [1:0] s);
        return BA_W'(s);
    endfunction

    always_comb begin
        cke  = (phase != PH_STAB);
        done = (phase == PH_DONE);
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        if (phase == PH_ISSUE) begin
            case (step)
                ST_PRE1, ST_PRE2: begin
                    cmd  = CMD_PRE;
                    addr = PRE_ALL;
                end
                ST_EMR2: begin
                    cmd = CMD_MRS; ba = sel(SEL_EMR2); addr = EMR2_OPS;
                end
                ST_EMR3: begin
                    cmd = CMD_MRS; ba = sel(SEL_EMR3); addr = EMR3_OPS;
                end
                ST_EMR1_DLL: begin
                    cmd = CMD_MRS; ba = sel(SEL_EMR1); addr = EMR1_BASE;
                end
                ST_MR_DLLRST: begin
                    cmd = CMD_MRS; ba = sel(SEL_MR); addr = MR_OPS | DLL_RST;
                end
                ST_REF: cmd = CMD_REF;
                ST_MR_RUN: begin
                    cmd = CMD_MRS; ba = sel(SEL_MR); addr = MR_OPS & ~DLL_RST;
                end
                ST_OCD_DFLT: begin
                    cmd = CMD_MRS; ba = sel(SEL_EMR1); addr = EMR1_BASE | OCD_MASK;
                end
                default: begin
                    cmd = CMD_MRS; ba = sel(SEL_EMR1); addr = EMR1_BASE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2i_pkg::*;
#(
    parameter int                ADDR_W   = 14,
    parameter int                BA_W     = 3,
    parameter int unsigned       T_STAB   = 20000,
    parameter int unsigned       T_CKE    = 40,
    parameter int unsigned       T_MRD    = 2,
    parameter int unsigned       T_RP     = 3,
    parameter int unsigned       T_RFC    = 20,
    parameter int unsigned       N_REF    = 2,
    parameter int unsigned       T_OCD    = 200,
    parameter logic [ADDR_W-1:0] MR_OPS   = 14'h0452,
    parameter logic [ADDR_W-1:0] EMR1_OPS = 14'h0044,
    parameter logic [ADDR_W-1:0] EMR2_OPS = '0,
    parameter logic [ADDR_W-1:0] EMR3_OPS = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              odt,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int unsigned T_MAX =
        max2(max2(T_STAB, T_CKE), max2(max2(T_MRD, T_RP), T_RFC));
    localparam int TW = $clog2(T_MAX + 1);

    logic          t_zero, t_load, age_ok, age_start;
    logic [TW-1:0] t_val;
    phase_e        phase;
    step_e         step;

    logic              enc_cke, enc_done;
    cmd_e              enc_cmd;
    logic [BA_W-1:0]   enc_ba;
    logic [ADDR_W-1:0] enc_addr;

    ddr2i_down_timer #(.W(TW), .RST_VAL(T_STAB - 1)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    ddr2i_age_timer #(.LIMIT(T_OCD)) u_age (
        .clk(clk), .rst(rst), .start(age_start), .reached(age_ok)
    );

    ddr2i_step_fsm #(
        .T_CKE(T_CKE), .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC),
        .N_REF(N_REF), .TW(TW)
    ) u_fsm (
        .clk(clk), .rst(rst), .t_zero(t_zero), .age_ok(age_ok),
        .t_load(t_load), .t_val(t_val), .age_start(age_start),
        .phase(phase), .step(step)
    );

    ddr2i_cmd_encode #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .MR_OPS(MR_OPS), .EMR1_OPS(EMR1_OPS),
        .EMR2_OPS(EMR2_OPS), .EMR3_OPS(EMR3_OPS)
    ) u_enc (
        .phase(phase), .step(step), .cke(enc_cke), .cmd(enc_cmd),
        .ba(enc_ba), .addr(enc_addr), .done(enc_done)
    );

    // Pin register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            cke                        <= 1'b0;
            odt                        <= 1'b0;
            {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
            ba                         <= '0;
            addr                       <= '0;
            init_done                  <= 1'b0;
        end else begin
            cke                        <= enc_cke;
            odt                        <= 1'b0;
            {cs_n, ras_n, cas_n, we_n} <= enc_cmd;
            ba                         <= enc_ba;
            addr                       <= enc_addr;
            init_done                  <= enc_done;
        end
    end
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
    parameter int          ADDR_W = 14,
    parameter int          BA_W   = 3,
    parameter int unsigned T_OCD  = 200
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              odt,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);
    localparam int CW = $clog2(T_OCD + 1);

    logic [3:0]    cmd;
    logic          dll_rst_cmd, ocd_dflt_cmd;
    logic          seen_q;
    logic [CW-1:0] age_q;

    assign cmd          = {cs_n, ras_n, cas_n, we_n};
    assign dll_rst_cmd  = (cmd == 4'b0000) && (ba[1:0] == 2'd0) && addr[8];
    assign ocd_dflt_cmd = (cmd == 4'b0000) && (ba[1:0] == 2'd1) && (addr[9:7] == 3'b111);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            age_q  <= '0;
        end else if (dll_rst_cmd) begin
            seen_q <= 1'b1;
            age_q  <= CW'(1);
        end else if (age_q != CW'(T_OCD) && age_q != '0) begin
            age_q  <= age_q + 1'b1;
        end
    end

    p_odt_low_r11: assert property (@(posedge clk) disable iff (rst) odt == 1'b0);
    p_cke_no_fall_r2: assert property (@(posedge clk) disable iff (rst) cke |=> cke);
    p_cke_low_nop_r2: assert property (@(posedge clk) disable iff (rst)
        !cke |-> cmd == 4'b0111);
    p_cmd_gap_r10: assert property (@(posedge clk) disable iff (rst)
        cmd != 4'b0111 |=> cmd == 4'b0111);
    p_ocd_window_r8: assert property (@(posedge clk) disable iff (rst)
        ocd_dflt_cmd |-> seen_q && age_q >= CW'(T_OCD));
    p_done_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);
    p_done_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        init_done |-> cke && cmd == 4'b0111);
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .T_OCD(T_OCD)
) u_chk (
    .clk(clk), .rst(rst), .cke(cke), .odt(odt), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
);

// File: tb/tb_ddr2_init_seq.sv
`timescale 1ns/1ps
module tb_ddr2_init_seq;

    localparam logic [13:0] A_MR = 14'h0452, A_E1 = 14'h0044;
    localparam logic [13:0] B_MR = 14'h0A63, B_E1 = 14'h03C5;

    logic clk = 1'b0;
    logic rst_a = 1'b1, rst_b = 1'b1;
    always #5 clk = ~clk;

    logic cke_a, odt_a, cs_a, ras_a, cas_a, we_a, done_a;
    logic [2:0]  ba_a;
    logic [13:0] addr_a;
    logic cke_b, odt_b, cs_b, ras_b, cas_b, we_b, done_b;
    logic [2:0]  ba_b;
    logic [13:0] addr_b;

    // Configuration A: defaults, impedance step must wait for the window
    ddr2_init_seq dut (
        .clk(clk), .rst(rst_a), .cke(cke_a), .odt(odt_a), .cs_n(cs_a),
        .ras_n(ras_a), .cas_n(cas_a), .we_n(we_a), .ba(ba_a), .addr(addr_a),
        .init_done(done_a)
    );

    // Configuration B: short waits, three refreshes, window already over
    ddr2_init_seq #(
        .T_STAB(5), .T_CKE(4), .T_MRD(3), .T_RP(2), .T_RFC(6), .N_REF(3),
        .T_OCD(12), .MR_OPS(B_MR), .EMR1_OPS(B_E1)
    ) dut_b (
        .clk(clk), .rst(rst_b), .cke(cke_b), .odt(odt_b), .cs_n(cs_b),
        .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b), .ba(ba_b), .addr(addr_b),
        .init_done(done_b)
    );

    // Packed view: {done, cke, odt, cmd[3:0], ba[2:0], addr[13:0]}
    logic [23:0] pk_a, pk_b;
    assign pk_a = {done_a, cke_a, odt_a, cs_a, ras_a, cas_a, we_a, ba_a, addr_a};
    assign pk_b = {done_b, cke_b, odt_b, cs_b, ras_b, cas_b, we_b, ba_b, addr_b};

    logic [23:0] exp_q[$];
    string       tag_q[$];
    int n_vec = 0, n_bad = 0;

    task automatic push(input logic d, input logic c, input logic [3:0] cmd,
                        input logic [2:0] b, input logic [13:0] a, input string t);
        exp_q.push_back({d, c, 1'b0, cmd, b, a});
        tag_q.push_back(t);
    endtask

    task automatic nops(input int n, input string t);
        for (int i = 0; i < n; i++) push(1'b0, 1'b1, 4'b0111, 3'd0, 14'd0, t);
    endtask

    task automatic build(input int tst, input int tck, input int tmrd, input int trp,
                         input int trfc, input int nref, input int tocd,
                         input logic [13:0] mr, input logic [13:0] e1);
        logic [13:0] base;
        int jd;
        base = e1 & ~14'h0381;
        for (int i = 0; i < tst; i++) push(1'b0, 1'b0, 4'b0111, 3'd0, 14'd0, "R2");
        nops(tck, "R3");
        push(1'b0, 1'b1, 4'b0010, 3'd0, 14'h0400, "R3");
        nops(trp, "R10");
        push(1'b0, 1'b1, 4'b0000, 3'd2, 14'd0, "R4");
        nops(tmrd, "R10");
        push(1'b0, 1'b1, 4'b0000, 3'd3, 14'd0, "R4");
        nops(tmrd, "R10");
        push(1'b0, 1'b1, 4'b0000, 3'd1, base, "R4");
        nops(tmrd, "R10");
        jd = exp_q.size();
        push(1'b0, 1'b1, 4'b0000, 3'd0, mr | 14'h0100, "R5");
        nops(tmrd, "R10");
        push(1'b0, 1'b1, 4'b0010, 3'd0, 14'h0400, "R5");
        nops(trp, "R10");
        for (int r = 0; r < nref; r++) begin
            push(1'b0, 1'b1, 4'b0001, 3'd0, 14'd0, "R6");
            nops(trfc, "R6");
        end
        push(1'b0, 1'b1, 4'b0000, 3'd0, mr & ~14'h0100, "R7");
        nops(tmrd, "R10");
        while (exp_q.size() < jd + tocd) nops(1, "R8");
        push(1'b0, 1'b1, 4'b0000, 3'd1, base | 14'h0380, "R8");
        nops(tmrd, "R9");
        push(1'b0, 1'b1, 4'b0000, 3'd1, base, "R9");
        nops(tmrd, "R12");
        for (int i = 0; i < 40; i++) push(1'b1, 1'b1, 4'b0111, 3'd0, 14'd0, "R12");
    endtask

    task automatic check(input logic [23:0] got, input logic [23:0] exp, input string t);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
        end
    endtask

    task automatic run(input bit use_b);
        logic [23:0] got;
        // R1: reset state
        @(negedge clk);
        got = use_b ? pk_b : pk_a;
        check(got, {3'b000, 4'b0111, 3'd0, 14'd0}, "R1");
        if (use_b) rst_b = 1'b0; else rst_a = 1'b0;
        while (exp_q.size() > 0) begin
            @(negedge clk);
            got = use_b ? pk_b : pk_a;
            check(got, exp_q.pop_front(), tag_q.pop_front());
            check({23'd0, got[21]}, 24'd0, "R11");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        build(20000, 40, 2, 3, 20, 2, 200, A_MR, A_E1);
        run(1'b0);
        build(5, 4, 3, 2, 6, 3, 12, B_MR, B_E1);
        run(1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule